// File: doc/BRIEF.md
# Counted Burst Pulse Generator

This block drives one output pin with a burst made of a set number of whole pulses. All pulses in a burst have the same shape. The pulse period is the block clock divided by a ratio chosen from a 4-bit divider code. A phase value sets how many clock cycles of each period are active, and a count value sets how many pulses the burst holds. Software sets the configuration through a small register write port and starts a burst by writing 1 to a start bit. That bit then reads 1 until the hardware clears it after the last whole pulse.

Three pin controls sit after the pulse logic. Polarity chooses the idle level. Gate holds the pin at its idle level while the timing logic keeps running. Tri-state drops the output enable. The block runs on one clock that has already been selected upstream.

Register map (2-bit address, 16-bit data, reads are combinational):

- Address 0, control: bit 0 start, bit 1 polarity, bit 2 gate, bit 3 tri-state.
- Address 1, divider code in bits [3:0].
- Address 2, phase in bits [9:0].
- Address 3, pulse count in bits [7:0].

Top module: `burst_gen`

## Requirements
- R1: A write to address 0 with bit 0 set, while no burst is running, makes the start bit read 1 from the next cycle, and the burst begins in that cycle.
- R2: While a burst runs, writes to address 0 never change the start bit, whether bit 0 is 0 or 1. Only burst completion clears it.
- R3: A burst with count N ≥ 1 holds the start bit at 1 for exactly N × period cycles and emits exactly N whole pulses. The bit reads 0 in the cycle that follows.
- R4: The period in cycles is DIV_BASE × (code[1:0] + 2) × 2^code[3:2]. With the default DIV_BASE of 16, code 4'b1011 gives 320.
- R5: Each period starts with `phase` active cycles, and the rest of the period is inactive. Phase 144 with period 320 gives 45% duty.
- R6: If phase ≥ period, every period of the burst is active throughout.
- R7: With polarity 0 the pin idles low and pulses are high. With polarity 1 both levels are inverted. When no burst runs, the pin sits at the idle level.
- R8: With gate set, the pin stays at its idle level for the whole burst. The start bit still runs the full length.
- R9: The output enable is the inverse of the tri-state bit.
- R10: Writes to addresses 1, 2 and 3 while a burst runs are ignored. Readback and the waveform keep the old values.
- R11: A count of 0 keeps the start bit at 1 for exactly one cycle and emits no active cycle.
- R12: After reset the start bit and all configuration fields are 0, the pin is low and the output enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; also the pulse time base |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| burst_o | output | 1 | Burst pin level |
| burst_oe_o | output | 1 | Burst pin output enable |

## Verification
The bench compares every cycle of each burst against a model. That catches an off-by-one in the period or in the pulse counter, which would show as a start bit that falls a period early or late, or a phase edge that lands one cycle off. Directed runs cover the following corner cases:

- Count 0: a design that underflows the pulse counter would run for 256 pulses.
- Phase at or above the period: a design that wraps the compare would emit no pulse at all.
- Gate: a design that cut the timing along with the pin would clear the start bit early.
- Writes issued in mid-burst: a design that changed period or phase in flight, or that let a 0 write clear the start bit, is exposed by the waveform and by readback.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // register addresses
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_DIV   = 2'd1,
        REG_PHASE = 2'd2,
        REG_COUNT = 2'd3
    } reg_addr_e;

    // control register bit positions
    localparam int unsigned CTRL_START_BIT = 0;
    localparam int unsigned CTRL_POL_BIT   = 1;
    localparam int unsigned CTRL_GATE_BIT  = 2;
    localparam int unsigned CTRL_TRI_BIT   = 3;

    localparam int unsigned DIV_CODE_W = 4;

    // pin shaping controls
    typedef struct packed {
        logic tri_en;
        logic gate;
        logic pol;
    } pin_ctrl_t;

    // largest divide ratio for a given base: multiplier 5, shift 3
    function automatic int unsigned max_ratio(int unsigned base);
        return base * 5 * 8;
    endfunction

    // period in clock cycles selected by a divider code
    function automatic int unsigned div_ratio(logic [DIV_CODE_W-1:0] code,
                                              int unsigned base);
        int unsigned mult;
        int unsigned scale;
        mult  = 32'(code[1:0]) + 2;
        scale = base << code[3:2];
        return mult * scale;
    endfunction

endpackage

// File: rtl/burst_regs.sv
module burst_regs
    import burst_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned PER_W    = 10,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned DIV_BASE = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [1:0]            rd_addr_i,
    output logic [DATA_W-1:0]     rd_data_o,
    input  logic                  busy_i,
    output logic                  launch_o,
    output pin_ctrl_t             pin_ctrl_o,
    output logic [PER_W-1:0]      ratio_o,
    output logic [PER_W-1:0]      phase_o,
    output logic [CNT_W-1:0]      count_o
);

    logic [DIV_CODE_W-1:0] div_code_q;
    logic [PER_W-1:0]      phase_q;
    logic [CNT_W-1:0]      count_q;
    pin_ctrl_t             pin_q;

    logic wr_ctrl, wr_div, wr_phase, wr_count;
    logic cfg_open;

    logic unused_wr;
    assign unused_wr = ^wr_data_i;

    assign cfg_open = !busy_i;
    assign wr_ctrl  = wr_en_i && (wr_addr_i == REG_CTRL);
    assign wr_div   = wr_en_i && (wr_addr_i == REG_DIV)   && cfg_open;
    assign wr_phase = wr_en_i && (wr_addr_i == REG_PHASE) && cfg_open;
    assign wr_count = wr_en_i && (wr_addr_i == REG_COUNT) && cfg_open;

    // a launch only when idle; start bit itself lives in the timer
    assign launch_o = wr_ctrl && wr_data_i[CTRL_START_BIT] && !busy_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_code_q <= '0;
            phase_q    <= '0;
            count_q    <= '0;
            pin_q      <= '0;
        end else begin
            if (wr_ctrl) begin
                pin_q.pol    <= wr_data_i[CTRL_POL_BIT];
                pin_q.gate   <= wr_data_i[CTRL_GATE_BIT];
                pin_q.tri_en <= wr_data_i[CTRL_TRI_BIT];
            end
            if (wr_div)   div_code_q <= wr_data_i[DIV_CODE_W-1:0];
            if (wr_phase) phase_q    <= wr_data_i[PER_W-1:0];
            if (wr_count) count_q    <= wr_data_i[CNT_W-1:0];
        end
    end

    assign ratio_o    = PER_W'(div_ratio(div_code_q, DIV_BASE));
    assign phase_o    = phase_q;
    assign count_o    = count_q;
    assign pin_ctrl_o = pin_q;

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            REG_CTRL: begin
                rd_data_o[CTRL_START_BIT] = busy_i;
                rd_data_o[CTRL_POL_BIT]   = pin_q.pol;
                rd_data_o[CTRL_GATE_BIT]  = pin_q.gate;
                rd_data_o[CTRL_TRI_BIT]   = pin_q.tri_en;
            end
            REG_DIV:   rd_data_o[DIV_CODE_W-1:0] = div_code_q;
            REG_PHASE: rd_data_o[PER_W-1:0]      = phase_q;
            default:   rd_data_o[CNT_W-1:0]      = count_q;
        endcase
    end

    // R10: configuration frozen while a burst runs
    p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_i && wr_en_i && (wr_addr_i != REG_CTRL)
        |=> $stable(div_code_q) && $stable(phase_q) && $stable(count_q));

endmodule

// File: rtl/burst_timer.sv
module burst_timer #(
    parameter int unsigned PER_W = 10,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             launch_i,
    input  logic [PER_W-1:0] ratio_i,
    input  logic [PER_W-1:0] phase_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             busy_o,
    output logic             active_o
);

    logic             busy_q;
    logic [PER_W-1:0] per_cnt_q;
    logic [CNT_W-1:0] pulse_cnt_q;

    logic             count_zero;
    logic             period_end;
    logic             last_pulse;
    logic [PER_W-1:0] ratio_m1;
    logic [CNT_W-1:0] count_m1;

    assign count_zero = (count_i == '0);
    assign ratio_m1   = ratio_i - PER_W'(1);
    assign count_m1   = count_i - CNT_W'(1);
    assign period_end = (per_cnt_q == ratio_m1);
    assign last_pulse = (pulse_cnt_q == count_m1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q      <= 1'b0;
            per_cnt_q   <= '0;
            pulse_cnt_q <= '0;
        end else if (launch_i) begin
            busy_q      <= 1'b1;
            per_cnt_q   <= '0;
            pulse_cnt_q <= '0;
        end else if (busy_q) begin
            if (count_zero) begin
                busy_q <= 1'b0;
            end else if (period_end) begin
                per_cnt_q <= '0;
                if (last_pulse) begin
                    busy_q <= 1'b0;
                end else begin
                    pulse_cnt_q <= pulse_cnt_q + CNT_W'(1);
                end
            end else begin
                per_cnt_q <= per_cnt_q + PER_W'(1);
            end
        end
    end

    // active phase leads each period; phase >= period keeps it active
    assign active_o = busy_q && !count_zero && (per_cnt_q < phase_i);
    assign busy_o   = busy_q;

    // R2: start bit only drops on completion
    p_start_sticky_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_q && !count_zero && !(period_end && last_pulse) |=> busy_q);

    // R3: the burst ends only after the final pulse
    p_done_count_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_q) |-> ($past(count_i) == '0) ||
                          ($past(pulse_cnt_q) == $past(count_m1)));

    // R4: period counter wraps only at ratio-1
    p_period_wrap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_q && $past(busy_q) && (per_cnt_q == '0) && !$past(count_zero)
        |-> $past(per_cnt_q) == $past(ratio_m1));

    // R11: empty burst lasts one cycle
    p_zero_count_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_q && count_zero && !launch_i |=> !busy_q);

    // R1: launch always raises the start bit
    p_launch_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        launch_i |=> busy_q);

endmodule

// File: rtl/burst_pin.sv
module burst_pin
    import burst_pkg::*;
(
    input  logic      active_i,
    input  pin_ctrl_t ctrl_i,
    output logic      pin_o,
    output logic      pin_oe_o
);

    logic shaped;

    always_comb begin
        if (ctrl_i.gate) begin
            shaped = 1'b0;
        end else begin
            shaped = active_i;
        end
        pin_o    = shaped ^ ctrl_i.pol;
        pin_oe_o = !ctrl_i.tri_en;
    end

endmodule

// File: rtl/burst_gen.sv
module burst_gen
    import burst_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned DIV_BASE = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              burst_o,
    output logic              burst_oe_o
);

    localparam int unsigned PER_W = $clog2(max_ratio(DIV_BASE) + 1);

    logic             busy;
    logic             launch;
    logic             active;
    pin_ctrl_t        pin_ctrl;
    logic [PER_W-1:0] ratio;
    logic [PER_W-1:0] phase;
    logic [CNT_W-1:0] count;

    burst_regs #(
        .DATA_W   (DATA_W),
        .PER_W    (PER_W),
        .CNT_W    (CNT_W),
        .DIV_BASE (DIV_BASE)
    ) regs_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .busy_i     (busy),
        .launch_o   (launch),
        .pin_ctrl_o (pin_ctrl),
        .ratio_o    (ratio),
        .phase_o    (phase),
        .count_o    (count)
    );

    burst_timer #(
        .PER_W (PER_W),
        .CNT_W (CNT_W)
    ) timer_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .launch_i (launch),
        .ratio_i  (ratio),
        .phase_i  (phase),
        .count_i  (count),
        .busy_o   (busy),
        .active_o (active)
    );

    burst_pin pin_i (
        .active_i (active),
        .ctrl_i   (pin_ctrl),
        .pin_o    (burst_o),
        .pin_oe_o (burst_oe_o)
    );

    // R7: idle level whenever no burst runs
    p_idle_level_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy |-> burst_o == pin_ctrl.pol);

    // R8: gated pin holds idle level
    p_gate_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        pin_ctrl.gate |-> burst_o == pin_ctrl.pol);

endmodule

// File: tb/burst_gen_tb_top.sv
module burst_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [1:0]  rd_addr;
    logic [15:0] rd_data;
    logic        burst;
    logic        burst_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    burst_gen dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .burst_o    (burst),
        .burst_oe_o (burst_oe)
    );

    function automatic int exp_period(int code);
        return 16 * ((code & 3) + 2) * (1 << ((code >> 2) & 3));
    endfunction

    function automatic bit exp_level(int k, int per, int ph, int cnt,
                                     bit pol, bit gate);
        int len;
        bit act;
        len = cnt * per;
        act = (cnt != 0) && (k < len) && ((k % per) < ph);
        if (gate) act = 1'b0;
        return act ^ pol;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(int addr, int data);
        wr_en   = 1'b1;
        wr_addr = 2'(addr);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic ctrl_word(bit start, bit pol, bit gate, bit tri_b, output int w);
        w = int'(start) | (int'(pol) << 1) | (int'(gate) << 2) | (int'(tri_b) << 3);
    endtask

    // compare every cycle from the first burst cycle to the first idle one
    task automatic check_burst(int per, int ph, int cnt, bit pol, bit gate,
                               bit tri_b, string tag);
        int len;
        int bad_lvl;
        int bad_start;
        int bad_oe;
        int act_pulses;
        bit prev;
        len = (cnt == 0) ? 1 : cnt * per;
        bad_lvl = 0; bad_start = 0; bad_oe = 0; act_pulses = 0;
        prev = pol;
        rd_addr = 2'd0;
        for (int k = 0; k <= len; k++) begin
            #1;
            if (burst !== exp_level(k, per, ph, cnt, pol, gate)) begin
                if (bad_lvl == 0)
                    $display("FAIL %s R5 level cycle %0d actual=%0d expected=%0d",
                             tag, k, burst, exp_level(k, per, ph, cnt, pol, gate));
                bad_lvl++;
            end
            if (rd_data[0] !== (k < len)) begin
                if (bad_start == 0)
                    $display("FAIL %s R3 start bit cycle %0d actual=%0d expected=%0d",
                             tag, k, rd_data[0], (k < len));
                bad_start++;
            end
            if (burst_oe !== !tri_b) bad_oe++;
            if ((burst ^ pol) && !(prev ^ pol)) act_pulses++;
            prev = burst;
            @(negedge clk);
        end
        n_checks += 3;
        if (bad_lvl != 0)   n_fails++;
        if (bad_start != 0) n_fails++;
        if (bad_oe != 0) begin
            n_fails++;
            $display("FAIL %s R9 oe actual=%0d expected=%0d", tag, burst_oe, !tri_b);
        end
        // R3: pulse edge count, leading edges only when active is visible
        if (!gate && ph > 0 && cnt > 0) begin
            int exp_p;
            exp_p = (ph >= per) ? 1 : cnt;
            chk(act_pulses == exp_p, "R3 pulse edges", act_pulses, exp_p);
        end
    endtask

    task automatic run_burst(int code, int ph, int cnt, bit pol, bit gate,
                             bit tri_b, string tag);
        int w;
        wr(1, code);
        wr(2, ph);
        wr(3, cnt);
        ctrl_word(1'b1, pol, gate, tri_b, w);
        wr(0, w);
        check_burst(exp_period(code), ph, cnt, pol, gate, tri_b, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        int w;
        void'($urandom(32'h5A17));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        #1;
        chk(burst == 1'b0, "R12 pin after reset", burst, 0);
        chk(burst_oe == 1'b1, "R12 oe after reset", burst_oe, 1);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #1;
            chk(rd_data == 16'd0, "R12 register after reset", rd_data, 0);
        end
        @(negedge clk);

        // R4 R5 R1: code 4'b1011 -> period 320, phase 144, 3 pulses
        chk(exp_period(11) == 320, "R4 model period", exp_period(11), 320);
        run_burst(11, 144, 3, 1'b0, 1'b0, 1'b0, "R4_example");

        // R7: inverted polarity
        run_burst(0, 10, 2, 1'b1, 1'b0, 1'b0, "R7_pol");
        // R8: gated
        run_burst(1, 20, 2, 1'b0, 1'b1, 1'b0, "R8_gate");
        // R9: tri-state
        run_burst(0, 5, 1, 1'b0, 1'b0, 1'b1, "R9_tri");
        // R6: phase equal to and beyond the period
        run_burst(0, 32, 2, 1'b0, 1'b0, 1'b0, "R6_equal");
        run_burst(2, 1000, 2, 1'b1, 1'b0, 1'b0, "R6_over");
        // phase 0: never active
        run_burst(0, 0, 2, 1'b0, 1'b0, 1'b0, "R5_zero_phase");
        // R11: empty burst
        run_burst(3, 10, 0, 1'b0, 1'b0, 1'b0, "R11_empty");

        // R2 R10: writes during a burst
        wr(1, 0); wr(2, 7); wr(3, 3);
        ctrl_word(1'b1, 1'b0, 1'b0, 1'b0, w);
        wr(0, w);
        fork
            check_burst(32, 7, 3, 1'b0, 1'b0, 1'b0, "R10_midwrite");
            begin
                int w0;
                int w1;
                repeat (20) @(negedge clk);
                wr(1, 15); wr(2, 3); wr(3, 200);
                ctrl_word(1'b0, 1'b0, 1'b0, 1'b0, w0);
                wr(0, w0);      // R2: zero write must not stop the burst
                ctrl_word(1'b1, 1'b0, 1'b0, 1'b0, w1);
                wr(0, w1);      // R2: repeat start ignored
            end
        join
        rd_addr = 2'd1; #1;
        chk(rd_data == 16'd0, "R10 divider kept", rd_data, 0);
        rd_addr = 2'd2; #1;
        chk(rd_data == 16'd7, "R10 phase kept", rd_data, 7);
        rd_addr = 2'd3; #1;
        chk(rd_data == 16'd3, "R10 count kept", rd_data, 3);
        @(negedge clk);

        // R1: writes while idle take effect and launch again
        run_burst(4, 30, 1, 1'b0, 1'b0, 1'b0, "R1_relaunch");

        // random bursts
        for (int i = 0; i < 14; i++) begin
            int code;
            int per;
            int ph;
            int cnt;
            code = int'($urandom % 12);
            per  = exp_period(code);
            ph   = int'($urandom % (per + 8));
            cnt  = int'($urandom % 5);
            run_burst(code, ph, cnt, 1'($urandom), 1'($urandom % 4 == 0),
                      1'($urandom % 4 == 0), "R5_random");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule